// File: doc/BRIEF.md
# Fractional Clock Pulse Swallower

The block turns a free-running parent clock into a clock-enable strobe that is high on M of every 32 parent cycles. Downstream logic that is clocked by the parent clock and qualified by the strobe runs at the parent rate times M/32. Software selects the rate through a 5-bit field, and the multiplier is 32 minus that field. A field of 0 therefore gives the full parent rate and a field of 31 gives one pulse per frame.

A new field value is only staged when it is written. It takes effect after software sets a commit flag in a second register. The hardware applies the staged value at the next 32-cycle frame boundary and then clears the flag, so software polls the flag to learn when the change is done. While a change is pending the staged value is locked, so the ratio that is applied is always the one that was written before the commit request. Within a frame an accumulator spreads the M enabled cycles as evenly as possible.

Top module: `pulse_swallower`

## Requirements
- R1: After synchronous reset the staged field is 0 and the commit flag is clear. Both register addresses then read as 0, and the strobe is high in every cycle.
- R2: A write to the ratio register (address 0) while the commit flag is clear stores write-data bits 12:8 as the staged field. The field reads back at bits 12:8 of both address 0 and address 1.
- R3: A write to the commit register (address 1) with write-data bit 31 set raises the commit flag. The flag reads back at bit 31 of both addresses. A write to address 1 with bit 31 clear leaves the flag unchanged.
- R4: A write to address 0 while the commit flag is set leaves the staged field unchanged.
- R5: Frame cycle 0 is the first cycle after reset is released, and frames are 32 cycles long. A commit flag that is already set during frame cycle 31 applies the staged ratio from the next frame cycle 0. A flag first set by a write during cycle 31 waits one more frame.
- R6: The commit flag reads 0 from the first cycle of the frame that uses the new ratio.
- R7: The multiplier M is 32 minus the applied field, and every frame contains exactly M strobe cycles.
- R8: With M applied, the strobe is high in frame cycle k (0..31) exactly when floor((k+1)·M/32) > floor(k·M/32).
- R9: Register bits other than 12:8 and 31 read as 0. Addresses other than 0 and 1 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| clk_en | output | 1 | Swallowed clock-enable strobe |

## Verification
Faults in the accumulator or in the applied multiplier show at the strobe within one frame. The bench counts the strobe cycles in each frame against M and compares every cycle with the closed-form spacing rule. A frame counter that drifts, or a commit taken at the wrong moment, shows up as a flag that clears in a cycle other than frame cycle 0, or as a frame whose pattern belongs to the old ratio. A staged field that is overwritten while a change is pending is visible on the very next read and in the following frame's pulse count.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_RATIO = 2'd1,
        SEL_KICK  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic       commit;
        logic       frame_last;
    } frame_evt_t;

    function automatic reg_sel_e decode_sel(
        input logic        wr,
        input int unsigned addr,
        input int unsigned ratio_addr,
        input int unsigned kick_addr
    );
        reg_sel_e s;
        s = SEL_NONE;
        if (wr) begin
            if (addr == ratio_addr)
                s = SEL_RATIO;
            else if (addr == kick_addr)
                s = SEL_KICK;
        end
        return s;
    endfunction

    function automatic logic addr_mapped(
        input int unsigned addr,
        input int unsigned ratio_addr,
        input int unsigned kick_addr
    );
        return (addr == ratio_addr) || (addr == kick_addr);
    endfunction

endpackage

// File: rtl/fps_regs.sv
module fps_regs
    import fps_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned FIELD_W    = 5,
    parameter int unsigned FIELD_LSB  = 8,
    parameter int unsigned KICK_BIT   = 31,
    parameter int unsigned RATIO_ADDR = 0,
    parameter int unsigned KICK_ADDR  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               commit,
    output logic [FIELD_W-1:0] field,
    output logic               kick
);

    reg_sel_e sel;
    logic     unused_wdata_parity;

    always_comb begin
        sel = decode_sel(wr, 32'(addr), RATIO_ADDR, KICK_ADDR);
    end

    assign unused_wdata_parity = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            field <= '0;
            kick  <= 1'b0;
        end else begin
            if (sel == SEL_RATIO && !kick)
                field <= wdata[FIELD_LSB +: FIELD_W];
            if (commit)
                kick <= 1'b0;
            else if (sel == SEL_KICK && wdata[KICK_BIT])
                kick <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_mapped(32'(addr), RATIO_ADDR, KICK_ADDR)) begin
            rdata[FIELD_LSB +: FIELD_W] = field;
            rdata[KICK_BIT]             = kick;
        end
    end

    // R1: reset leaves both state elements cleared
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (field == '0 && !kick));

    // R4: staged field is frozen while a change is pending
    assert_ratio_locked_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_W'(RATIO_ADDR) && kick) |=> $stable(field));

    // R6: flag drops right after the commit
    assert_kick_drop_R6: assert property (@(posedge clk) disable iff (rst)
        commit |=> !kick);

    // R3: flag only rises on a commit-register write
    assert_kick_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(kick) |-> $past(wr && addr == ADDR_W'(KICK_ADDR) && wdata[KICK_BIT]));

endmodule

// File: rtl/fps_frame.sv
module fps_frame
    import fps_pkg::*;
#(
    parameter int unsigned FRAME_LOG2 = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kick,
    output frame_evt_t evt
);

    logic [FRAME_LOG2-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else
            pos <= pos + 1'b1;
    end

    always_comb begin
        evt.frame_last = &pos;
        evt.commit     = kick & evt.frame_last;
    end

    // R5: the cycle after the last one of a frame is cycle 0
    assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        evt.frame_last |=> (pos == '0));

endmodule

// File: rtl/fps_pattern.sv
module fps_pattern #(
    parameter int unsigned FRAME_LOG2 = 5,
    localparam int unsigned MULT_W    = FRAME_LOG2 + 1,
    localparam int unsigned FRAME_LEN = 1 << FRAME_LOG2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_LOG2-1:0] load_field,
    input  logic                  frame_last,
    output logic                  clk_en
);

    logic [MULT_W-1:0]     mult;
    logic [FRAME_LOG2-1:0] acc;
    logic [MULT_W-1:0]     sum;

    always_comb begin
        sum    = {1'b0, acc} + mult;
        clk_en = sum[FRAME_LOG2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mult <= MULT_W'(FRAME_LEN);
            acc  <= '0;
        end else begin
            if (frame_last)
                acc <= '0;
            else
                acc <= sum[FRAME_LOG2-1:0];
            if (load)
                mult <= MULT_W'(FRAME_LEN) - MULT_W'(load_field);
        end
    end

    // checker-side pulse counter for the per-frame total
    logic [MULT_W-1:0] chk_pulses;

    always_ff @(posedge clk) begin
        if (rst || frame_last)
            chk_pulses <= '0;
        else
            chk_pulses <= chk_pulses + MULT_W'(clk_en);
    end

    // R7: each frame carries exactly M pulses
    assert_frame_pulses_R7: assert property (@(posedge clk) disable iff (rst)
        frame_last |-> ((chk_pulses + MULT_W'(clk_en)) == mult));

    // R5: the multiplier only changes across a frame boundary
    assert_mult_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        (mult != $past(mult)) |-> $past(frame_last));

    // R7: full multiplier never swallows a cycle
    assert_full_rate_R7: assert property (@(posedge clk) disable iff (rst)
        (mult == MULT_W'(FRAME_LEN)) |-> clk_en);

endmodule

// File: rtl/pulse_swallower.sv
module pulse_swallower
    import fps_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned FRAME_LOG2 = 5,
    parameter int unsigned FIELD_LSB  = 8,
    parameter int unsigned KICK_BIT   = 31,
    parameter int unsigned RATIO_ADDR = 0,
    parameter int unsigned KICK_ADDR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);

    logic [FRAME_LOG2-1:0] staged_field;
    logic                  kick;
    frame_evt_t            evt;

    fps_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .FIELD_W    (FRAME_LOG2),
        .FIELD_LSB  (FIELD_LSB),
        .KICK_BIT   (KICK_BIT),
        .RATIO_ADDR (RATIO_ADDR),
        .KICK_ADDR  (KICK_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .commit (evt.commit),
        .field  (staged_field),
        .kick   (kick)
    );

    fps_frame #(
        .FRAME_LOG2 (FRAME_LOG2)
    ) u_frame (
        .clk  (clk),
        .rst  (rst),
        .kick (kick),
        .evt  (evt)
    );

    fps_pattern #(
        .FRAME_LOG2 (FRAME_LOG2)
    ) u_pattern (
        .clk        (clk),
        .rst        (rst),
        .load       (evt.commit),
        .load_field (staged_field),
        .frame_last (evt.frame_last),
        .clk_en     (clk_en)
    );

endmodule

// File: tb/test_pulse_swallower.sv
module test_pulse_swallower;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int checks = 0;
    int errors = 0;
    logic [4:0] fc;
    logic [31:0] rv;

    localparam int NVEC = 8;
    localparam int VEC_FIELD [NVEC] = '{0, 1, 31, 16, 5, 24, 13, 30};
    localparam int VEC_MULT  [NVEC] = '{32, 31, 1, 16, 27, 8, 19, 2};

    always #10 clk = ~clk;

    pulse_swallower i_pulse_swallower (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk_en    (clk_en)
    );

    // frame position per R5: cycle 0 is the first cycle after reset release
    always @(posedge clk) begin
        if (rst) fc <= '0;
        else     fc <= fc + 1'b1;
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_fc(input int v);
        while (fc != 5'(v)) @(negedge clk);
    endtask

    // call at negedge of frame cycle 0; checks R8 per cycle and R7 total
    task automatic check_frame(input int m);
        int cnt = 0;
        for (int k = 0; k < 32; k++) begin
            logic e;
            e = (((k + 1) * m) / 32) != ((k * m) / 32);
            chk(clk_en == e, "R8", clk_en, e);
            cnt += int'(clk_en);
            @(negedge clk);
        end
        chk(cnt == m, "R7", cnt, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(4'd0, rv); chk(rv == 0, "R1", rv, 0);
        rd(4'd1, rv); chk(rv == 0, "R1", rv, 0);
        check_frame(32);

        // R3: commit write with bit 31 clear leaves flag low
        wr(4'd1, 32'h7fff_ffff);
        rd(4'd1, rv); chk(rv[31] == 1'b0, "R3", rv[31], 0);
        // R9: unmapped address writes ignored and read zero
        wr(4'd5, 32'hffff_ffff);
        rd(4'd5, rv); chk(rv == 0, "R9", rv, 0);
        rd(4'd0, rv); chk(rv == 0, "R9", rv, 0);
        // R9/R2: only the field bits stick
        wr(4'd0, 32'hffff_ffff);
        rd(4'd0, rv); chk(rv == 32'h0000_1f00, "R9", rv, 32'h1f00);

        // vector table: R2, R3, R4, R5, R6, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            logic [4:0] f;
            f = 5'(VEC_FIELD[i]);
            wait_fc(2);
            wr(4'd0, 32'(f) << 8);
            rd(4'd1, rv); chk(rv[12:8] == f, "R2", rv[12:8], f);
            wr(4'd1, 32'h8000_0000);
            rd(4'd0, rv); chk(rv[31] == 1'b1, "R3", rv[31], 1);
            wr(4'd0, 32'(f ^ 5'h15) << 8);
            rd(4'd0, rv); chk(rv[12:8] == f, "R4", rv[12:8], f);
            wait_fc(31);
            rd(4'd1, rv); chk(rv[31] == 1'b1, "R5", rv[31], 1);
            @(negedge clk);
            rd(4'd1, rv); chk(rv[31] == 1'b0, "R6", rv[31], 0);
            check_frame(VEC_MULT[i]);
        end

        // R5: a flag first set during cycle 31 waits a further frame
        wait_fc(2);
        wr(4'd0, 32'd8 << 8);
        wait_fc(31);
        wr(4'd1, 32'h8000_0000);
        rd(4'd1, rv); chk(rv[31] == 1'b1, "R5", rv[31], 1);
        check_frame(2);
        rd(4'd1, rv); chk(rv[31] == 1'b0, "R6", rv[31], 0);
        check_frame(24);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule